// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a synchronous up-counter slice that can be preset from a parallel bus and chained into wider counters or programmable dividers. Each slice holds `WIDTH` bits (four by default) and counts in plain binary order. When every bit is one, the next counting edge takes it back to zero. A slice has two count enables. The first is a count enable shared by the whole chain. The second is a chain enable that arrives from the slice below. The terminal-count flag of a slice is gated only by its chain enable, and it feeds the chain enable of the slice above. As a result, every slice of a wide count steps on the same clock edge and nothing ripples from one slice to the next.

Four modes are ranked in a fixed order: clear, then preset, then count, then hold. A parameter sets whether the active-low clear acts at once or waits for the next rising clock edge. The top level is a cascade of `STAGES` slices. It exposes the whole count and each slice's terminal-count flag. Without the asynchronous clear, the count register changes only on the rising edge of `clk`.

Top module: `pcnt_chain`

## Requirements
- R1: With `ASYNC_CLR` = 0, `clr_n` low at a rising edge of `clk` makes `count` all zeros after that edge, whatever `load_n`, `cnt_en` and `chain_en` are. While `clr_n` is low between edges, `count` does not change.
- R2: With `ASYNC_CLR` = 1, `clr_n` going low forces `count` to zero at once, with no clock edge. While `clr_n` stays low, it overrides the preset and both enables.
- R3: With `clr_n` high, `load_n` low at a rising edge copies `load_val` into `count`, whatever `cnt_en` and `chain_en` are.
- R4: With `clr_n` and `load_n` high, and both `cnt_en` and `chain_en` high, `count` increases by one on each rising edge.
- R5: With `clr_n` and `load_n` high, `count` keeps its value across a rising edge if `cnt_en` or `chain_en` is low.
- R6: When the whole count is all ones and counting is enabled, the next edge makes it zero.
- R7: `stage_tc[k]` is high exactly when that slice's chain enable is high and its `WIDTH` count bits are all ones. `cnt_en` has no effect on it, and it has no register in its path.
- R8: The chain enable of slice 0 is `chain_en`. For slice k > 0, it is `stage_tc[k-1]`. Every slice takes `cnt_en`, so the full `STAGES*WIDTH`-bit count carries between slices within a single clock edge. Slice k occupies bits `[k*WIDTH +: WIDTH]` of `count`.
- R9: The terminal count is decoded as all ones at any `WIDTH` (for example, 3-bit slices flag at 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, immediate or edge-timed by `ASYNC_CLR` |
| load_n | input | 1 | Active-low preset enable |
| cnt_en | input | 1 | Count enable shared by all slices |
| chain_en | input | 1 | Chain enable into slice 0 |
| load_val | input | STAGES*WIDTH | Preset value |
| count | output | STAGES*WIDTH | Current count |
| stage_tc | output | STAGES | Terminal-count flag of each slice |

## Verification
Clear (edge-timed), preset, count and hold take effect on the first rising edge after the inputs are applied. The bench drives inputs at a falling edge and compares `count` at the next falling edge, with exactly one register between them. The terminal-count flags are combinational, so each is compared in the same half-cycle as the count it decodes, with the enables still applied. The immediate clear is checked one time unit after `clr_n` falls, before any rising edge. At the same instant, the edge-timed instance must still show its old count.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } pcnt_mode_e;

  localparam int unsigned MAX_W = 32;

  // Priority: clear, preset, count, hold.
  function automatic pcnt_mode_e pick_mode(input logic clr_req, input logic load_n,
                                           input logic par_en, input logic chn_en);
    if (clr_req)              return MODE_CLEAR;
    else if (!load_n)         return MODE_LOAD;
    else if (par_en && chn_en) return MODE_COUNT;
    else                      return MODE_HOLD;
  endfunction

  // Increment modulo 2**w.
  function automatic logic [MAX_W-1:0] incr_wrap(input logic [MAX_W-1:0] v,
                                                 input int unsigned w);
    logic [MAX_W-1:0] mask;
    mask = {MAX_W{1'b1}} >> (MAX_W - w);
    return (v + 1'b1) & mask;
  endfunction

  // True when the low w bits are all ones.
  function automatic logic all_ones(input logic [MAX_W-1:0] v, input int unsigned w);
    logic [MAX_W-1:0] mask;
    mask = {MAX_W{1'b1}} >> (MAX_W - w);
    return (v & mask) == mask;
  endfunction

endpackage

// File: rtl/pcnt_mode_dec.sv
module pcnt_mode_dec
  import pcnt_pkg::*;
(
  input  logic       clr_req,
  input  logic       load_n,
  input  logic       par_en,
  input  logic       chn_en,
  output pcnt_mode_e mode
);
  always_comb mode = pick_mode(clr_req, load_n, par_en, chn_en);
endmodule

// File: rtl/pcnt_tc_dec.sv
module pcnt_tc_dec
  import pcnt_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             chn_en,
  output logic             tc
);
  localparam int unsigned PADW = MAX_W - WIDTH;
  logic [MAX_W-1:0] q_wide;

  generate
    if (PADW == 0) begin : g_full
      always_comb q_wide = q;
    end else begin : g_pad
      always_comb q_wide = {{PADW{1'b0}}, q};
    end
  endgenerate

  always_comb tc = chn_en && all_ones(q_wide, WIDTH);
endmodule

// File: rtl/pcnt_stage.sv
module pcnt_stage
  import pcnt_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter bit          ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             par_en,
  input  logic             chn_en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             tc,
  output logic             inc_evt
);
  localparam int unsigned PADW = MAX_W - WIDTH;

  pcnt_mode_e       mode;
  logic             clr_req;
  logic [WIDTH-1:0] q_next;
  logic [WIDTH-1:0] q_inc;
  logic [MAX_W-1:0] q_wide;
  logic [MAX_W-1:0] inc_wide;

  // The immediate variant clears through the register reset, not the mode.
  assign clr_req = ASYNC_CLR ? 1'b0 : !clr_n;

  pcnt_mode_dec u_mode (
    .clr_req (clr_req),
    .load_n  (load_n),
    .par_en  (par_en),
    .chn_en  (chn_en),
    .mode    (mode)
  );

  generate
    if (PADW == 0) begin : g_full
      always_comb q_wide = q;
    end else begin : g_pad
      always_comb q_wide = {{PADW{1'b0}}, q};
    end
  endgenerate

  always_comb begin
    inc_wide = incr_wrap(q_wide, WIDTH);
    q_inc    = inc_wide[WIDTH-1:0];
  end

  always_comb begin
    unique case (mode)
      MODE_CLEAR: q_next = '0;
      MODE_LOAD:  q_next = d;
      MODE_COUNT: q_next = q_inc;
      default:    q_next = q;
    endcase
  end

  assign inc_evt = (mode == MODE_COUNT);

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= q_next;
      end
    end else begin : g_sync
      always_ff @(posedge clk) q <= q_next;
    end
  endgenerate

  pcnt_tc_dec #(.WIDTH(WIDTH)) u_tc (
    .q      (q),
    .chn_en (chn_en),
    .tc     (tc)
  );
endmodule

// File: rtl/pcnt_chain.sv
module pcnt_chain #(
  parameter int unsigned WIDTH     = 4,
  parameter int unsigned STAGES    = 2,
  parameter bit          ASYNC_CLR = 1'b0
) (
  input  logic                      clk,
  input  logic                      clr_n,
  input  logic                      load_n,
  input  logic                      cnt_en,
  input  logic                      chain_en,
  input  logic [STAGES*WIDTH-1:0]   load_val,
  output logic [STAGES*WIDTH-1:0]   count,
  output logic [STAGES-1:0]         stage_tc
);
  localparam int unsigned TOTAL_W = STAGES * WIDTH;

  // Named per-slice events for the checker.
  logic [STAGES-1:0] stage_chn;
  logic [STAGES-1:0] stage_inc;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        assign stage_chn[k] = chain_en;
      end else begin : g_next
        assign stage_chn[k] = stage_tc[k-1];
      end

      pcnt_stage #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_stage (
        .clk     (clk),
        .clr_n   (clr_n),
        .load_n  (load_n),
        .par_en  (cnt_en),
        .chn_en  (stage_chn[k]),
        .d       (load_val[k*WIDTH +: WIDTH]),
        .q       (count[k*WIDTH +: WIDTH]),
        .tc      (stage_tc[k]),
        .inc_evt (stage_inc[k])
      );
    end
  endgenerate

  logic [TOTAL_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/pcnt_chain_chk.sv
module pcnt_chain_chk #(
  parameter int unsigned WIDTH     = 4,
  parameter int unsigned STAGES    = 2,
  parameter bit          ASYNC_CLR = 1'b0
) (
  input logic                    clk,
  input logic                    clr_n,
  input logic                    load_n,
  input logic                    cnt_en,
  input logic                    chain_en,
  input logic [STAGES*WIDTH-1:0] load_val,
  input logic [STAGES*WIDTH-1:0] count,
  input logic [STAGES-1:0]       stage_tc,
  input logic [STAGES-1:0]       stage_inc
);
  localparam int unsigned TOTAL_W = STAGES * WIDTH;

  // Armed once a clear has been seen at an edge.
  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) armed <= 1'b1;

  a_r1_sync_clear: assert property (@(posedge clk) disable iff (!armed)
    (!ASYNC_CLR && !clr_n) |=> (count == '0));

  a_r2_async_clear: assert property (@(posedge clk) disable iff (!armed)
    (ASYNC_CLR && !clr_n) |-> (count == '0));

  a_r3_load: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !load_n) |=> (!clr_n || count == $past(load_val)));

  a_r4_increment: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && cnt_en && chain_en) |=>
      (!clr_n || count == $past(count) + TOTAL_W'(1)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && !(cnt_en && chain_en)) |=> (!clr_n || $stable(count)));

  a_r6_rollover: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && cnt_en && chain_en && (&count)) |=> (!clr_n || count == '0));

  a_r7_tc_needs_chain: assert property (@(posedge clk) disable iff (!armed)
    !chain_en |-> (stage_tc == '0));

  a_r9_tc_all_ones: assert property (@(posedge clk) disable iff (!armed)
    stage_tc[0] |-> (&count[WIDTH-1:0]));

  a_r8_upper_steps_only_on_carry: assert property (@(posedge clk) disable iff (!armed)
    (STAGES > 1 && stage_inc[STAGES-1]) |-> $onehot0(~stage_tc[STAGES-2:0] & {(STAGES-1){1'b1}}) && (stage_tc[STAGES-2:0] == {(STAGES-1){1'b1}}));
endmodule

bind pcnt_chain pcnt_chain_chk #(
  .WIDTH(WIDTH), .STAGES(STAGES), .ASYNC_CLR(ASYNC_CLR)
) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .load_n    (load_n),
  .cnt_en    (cnt_en),
  .chain_en  (chain_en),
  .load_val  (load_val),
  .count     (count),
  .stage_tc  (stage_tc),
  .stage_inc (stage_inc)
);

// File: tb/pcnt_chain_tb.sv
module pcnt_chain_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // Edge-timed clear, 2 x 4 bits.
  logic       clr_n = 1'b0, load_n = 1'b1, cnt_en = 1'b0, chain_en = 1'b0;
  logic [7:0] load_val = '0;
  logic [7:0] count;
  logic [1:0] stage_tc;

  pcnt_chain #(.WIDTH(4), .STAGES(2), .ASYNC_CLR(1'b0)) u_dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .chain_en(chain_en), .load_val(load_val), .count(count), .stage_tc(stage_tc));

  // Immediate clear, 3 x 3 bits.
  logic       a_clr_n = 1'b0, a_load_n = 1'b1, a_cnt_en = 1'b0, a_chain_en = 1'b0;
  logic [8:0] a_load_val = '0;
  logic [8:0] a_count;
  logic [2:0] a_stage_tc;

  pcnt_chain #(.WIDTH(3), .STAGES(3), .ASYNC_CLR(1'b1)) u_dut_async (
    .clk(clk), .clr_n(a_clr_n), .load_n(a_load_n), .cnt_en(a_cnt_en),
    .chain_en(a_chain_en), .load_val(a_load_val), .count(a_count), .stage_tc(a_stage_tc));

  // {clr_n, load_n, cnt_en, chain_en, load_val[7:0], expected count[7:0]}
  localparam int NV = 19;
  localparam logic [19:0] VEC [NV] = '{
    {4'b0100, 8'h00, 8'h00},
    {4'b1000, 8'h0E, 8'h0E},
    {4'b1111, 8'h00, 8'h0F},
    {4'b1111, 8'h00, 8'h10},
    {4'b1101, 8'h00, 8'h10},
    {4'b1110, 8'h00, 8'h10},
    {4'b1011, 8'hFE, 8'hFE},
    {4'b1111, 8'h00, 8'hFF},
    {4'b1111, 8'h00, 8'h00},
    {4'b0011, 8'h3C, 8'h00},
    {4'b1000, 8'h5F, 8'h5F},
    {4'b1101, 8'h00, 8'h5F},
    {4'b1111, 8'h00, 8'h60},
    {4'b1000, 8'hA7, 8'hA7},
    {4'b1111, 8'h00, 8'hA8},
    {4'b1100, 8'h00, 8'hA8},
    {4'b1001, 8'hFF, 8'hFF},
    {4'b1101, 8'h00, 8'hFF},
    {4'b1100, 8'h00, 8'hFF}
  };

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic string row_tag(input logic [3:0] ctl, input logic [7:0] exp);
    if (!ctl[3])              return "R1";
    else if (!ctl[2])         return "R3";
    else if (ctl[1] && ctl[0]) begin
      if (exp == 8'h00)       return "R6";
      else if (exp[3:0] == 0) return "R8";
      else                    return "R4";
    end else                  return "R5";
  endfunction

  // Reference flags from the expected count: slice 0 gated by chain_en,
  // slice 1 gated by slice 0's flag.
  function automatic logic [1:0] ref_tc(input logic te, input logic [7:0] c);
    logic t0;
    t0 = te && (c[3:0] == 4'hF);
    return {t0 && (c[7:4] == 4'hF), t0};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
      finish_run();
    end
  end

  initial begin
    // Reset state: both clears held over two edges.
    @(negedge clk);
    @(negedge clk);
    check("R1 reset", count, 0);
    check("R2 reset", a_count, 0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] ctl;
      logic [7:0] exp;
      ctl      = VEC[i][19:16];
      exp      = VEC[i][7:0];
      clr_n    = ctl[3];
      load_n   = ctl[2];
      cnt_en   = ctl[1];
      chain_en = ctl[0];
      load_val = VEC[i][15:8];
      @(negedge clk);
      check(row_tag(ctl, exp), count, exp);
      check("R7 tc", stage_tc, ref_tc(ctl[0], exp));
    end

    // Flag ignores cnt_en; chain_en low clears both flags (count is FF).
    clr_n = 1'b1; load_n = 1'b1; cnt_en = 1'b1; chain_en = 1'b0;
    #1 check("R7 tc chain low", stage_tc, 2'b00);
    chain_en = 1'b1; cnt_en = 1'b0;
    #1 check("R7 tc pe low", stage_tc, 2'b11);

    // Edge-timed clear must wait for the edge (count FF before).
    @(negedge clk);
    load_n = 1'b0; load_val = 8'h99; cnt_en = 1'b1; clr_n = 1'b0;
    #1 check("R1 no early clear", count, 8'hFF);
    @(negedge clk);
    check("R1 clear over load", count, 8'h00);
    clr_n = 1'b1; load_n = 1'b1; cnt_en = 1'b0;

    // Immediate-clear instance, 3-bit slices.
    a_clr_n = 1'b1; a_load_n = 1'b0; a_load_val = 9'h1FE;
    @(negedge clk);
    check("R3 async load", a_count, 9'h1FE);
    a_load_n = 1'b1; a_cnt_en = 1'b1; a_chain_en = 1'b1;
    @(negedge clk);
    check("R9 count to all ones", a_count, 9'h1FF);
    check("R9 tc at 7 per slice", a_stage_tc, 3'b111);
    @(negedge clk);
    check("R9 rollover", a_count, 9'h000);
    check("R9 tc after wrap", a_stage_tc, 3'b000);
    a_cnt_en = 1'b0; a_load_n = 1'b0; a_load_val = 9'h055;
    @(negedge clk);
    check("R3 async load 2", a_count, 9'h055);
    a_clr_n = 1'b0;
    #1 check("R2 immediate clear", a_count, 9'h000);
    a_cnt_en = 1'b1;
    @(negedge clk);
    check("R2 clear held over load", a_count, 9'h000);
    a_clr_n = 1'b1; a_load_n = 1'b1;
    @(negedge clk);
    check("R4 count after clear", a_count, 9'h001);

    finish_run();
  end
endmodule